// File: doc/BRIEF.md
# Power-Up Configuration Restore Sequencer

This block brings volatile configuration back after power is applied. It waits for a logic input that reports the supply has cleared its undervoltage lockout level. It then reads every word of a nonvolatile array in ascending address order, one word per cycle, and writes each word into the front (A) side of the matching double-buffered configuration latch. Once the last A write has landed, it issues a single global pulse. That pulse moves every A latch into its B latch at the same moment, and the download is complete.

A fixed settling delay of `SETTLE_US` microseconds follows the commit, sized from the `CLK_HZ` parameter. After that delay the block pulses a start signal so the downstream state engine can load its first state. From reset until the commit, a busy flag is held. While busy is set, every host bus request is answered with a not-acknowledge. The host can rerun the whole download later to restore the programmed configuration. The block also gates nonvolatile page-erase commands behind an erase-enable bit.

Top module: `cfg_restore_seq`

## Requirements
- R1: After reset `busy` is 1, and `nv_rd_en`, `a_wr_en`, `commit_b` and `se_load` are 0. No read or write takes place while `supply_ok` stays 0.
- R2: When `supply_ok` is 1, the block reads addresses 0 to DEPTH-1 in ascending order, one per cycle. Read data arrives one cycle after the address. In the cycle the data arrives, it is written to the A latch at the same address, so `a_wr_addr` equals the address that was read and `a_wr_data` equals the data that came back.
- R3: `commit_b` is a pulse exactly one cycle wide. It fires once per download, in the cycle after the write to address DEPTH-1, and never in a cycle that has an A write.
- R4: Outside a download, `a_wr_en` stays 0. Within a download, each A write after address 0 targets the address one above the previous write.
- R5: `busy` stays 1 until the commit pulse and is 0 in the cycle after it.
- R6: A host request (`host_req`=1) gives `host_nack`=1 and `host_ack`=0 while `busy` is 1. It gives `host_ack`=1 and `host_nack`=0 when `busy` is 0.
- R7: `se_load` is a one-cycle pulse exactly SETTLE_CYC+1 cycles after `commit_b`, where SETTLE_CYC = CLK_HZ/1,000,000 × SETTLE_US.
- R8: A `reload_req` while `busy` is 0 raises `busy` in the next cycle. It then reruns the full download: DEPTH A writes, one commit and one `se_load`.
- R9: A `reload_req` while `busy` is 1 is ignored. The running download still performs exactly DEPTH A writes and one commit.
- R10: `erase_fire` goes to 1 one cycle after `erase_req`, with `erase_page` equal to the requested page, only when `erase_allow` is 1. When `erase_allow` is 0, the request leaves `erase_fire` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply is above the undervoltage lockout level |
| reload_req | input | 1 | Host command to rerun the download |
| host_req | input | 1 | Host bus transaction attempt |
| host_ack | output | 1 | Transaction accepted |
| host_nack | output | 1 | Transaction refused |
| busy | output | 1 | Download in progress |
| nv_rd_en | output | 1 | Nonvolatile read strobe |
| nv_rd_addr | output | ADDR_W | Nonvolatile read address |
| nv_rd_data | input | DATA_W | Read data, one cycle after the address |
| a_wr_en | output | 1 | A-latch write strobe |
| a_wr_addr | output | ADDR_W | A-latch address |
| a_wr_data | output | DATA_W | A-latch data |
| commit_b | output | 1 | Global A-to-B transfer pulse |
| se_load | output | 1 | Start pulse for the state engine |
| erase_req | input | 1 | Page erase command |
| erase_allow | input | 1 | Erase-enable bit |
| erase_page_in | input | PAGE_W | Page to erase |
| erase_fire | output | 1 | Erase issued to storage |
| erase_page | output | PAGE_W | Page being erased |

## Verification
The bench builds the block with DEPTH=8 and CLK_HZ=4 MHz, which gives a settling window of 2000 cycles. With these values, several complete downloads, including the exact commit-to-start distance, fit into a short run. The small depth puts the last-address boundary and the commit that follows it within a handful of cycles. This makes the write order, the single-commit rule and the handling of a reload that arrives mid-walk directly observable.

// File: rtl/cfg_restore_pkg.sv
// Shared types and helpers for the configuration restore sequencer.
package cfg_restore_pkg;

    // Controller phases of a download.
    typedef enum logic [2:0] {
        PH_WAIT   = 3'd0,
        PH_FILL   = 3'd1,
        PH_COMMIT = 3'd2,
        PH_SETTLE = 3'd3,
        PH_LAUNCH = 3'd4,
        PH_RUN    = 3'd5
    } phase_t;

    // Settling window in clock cycles, never below one.
    function automatic int settle_cycles(input longint clk_hz, input longint usec);
        longint c;
        c = (clk_hz / 64'd1000000) * usec;
        return (c < 1) ? 1 : int'(c);
    endfunction

endpackage

// File: rtl/cfg_addr_walker.sv
// Address walker: issues ascending reads 0..DEPTH-1, one per cycle, and turns
// each returned word into an A-latch write one cycle later.
// Assumes read data is valid exactly one cycle after the read strobe.
module cfg_addr_walker #(
    parameter int DEPTH  = 48,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              done
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    logic              active;
    logic [ADDR_W-1:0] idx;
    logic              wr_q;
    logic              last_q;
    logic [ADDR_W-1:0] wr_addr_q;

    // Read pointer: restart on start, step until the last address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
        end else if (start) begin
            active <= 1'b1;
            idx    <= '0;
        end else if (active) begin
            if (idx == LAST) begin
                active <= 1'b0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    // Write stage: align address with the returning data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q      <= 1'b0;
            last_q    <= 1'b0;
            wr_addr_q <= '0;
        end else begin
            wr_q      <= active;
            last_q    <= active && (idx == LAST);
            wr_addr_q <= idx;
        end
    end

    // Output mapping for read, write and completion.
    always_comb begin
        rd_en   = active;
        rd_addr = idx;
        wr_en   = wr_q;
        wr_addr = wr_addr_q;
        wr_data = rd_data;
        done    = wr_q && last_q;
    end
endmodule

// File: rtl/cfg_settle_timer.sv
// Settling timer: counts CYCLES cycles while run is high, restarts on clear.
// Assumes clear and run are never high together.
module cfg_settle_timer #(
    parameter int CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES + 1) : 1;
    localparam logic [CNT_W-1:0] END_VAL = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Count up while running, hold at the end value.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (run && cnt != END_VAL) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Flag the final counted cycle.
    always_comb expired = run && (cnt == END_VAL);
endmodule

// File: rtl/cfg_restore_ctrl.sv
// Download controller: sequences wait, fill, commit, settle and launch.
// Drives busy and the phase pulses; a reload is honoured only when not busy.
module cfg_restore_ctrl
    import cfg_restore_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic reload_req,
    input  logic walk_done,
    input  logic settle_done,
    output logic walk_start,
    output logic settle_clear,
    output logic settle_run,
    output logic commit_b,
    output logic se_load,
    output logic busy
);
    phase_t ph, ph_nxt;

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) ph <= PH_WAIT;
        else        ph <= ph_nxt;
    end

    // Next-phase selection.
    always_comb begin
        ph_nxt = ph;
        unique case (ph)
            PH_WAIT:   if (supply_ok) ph_nxt = PH_FILL;
            PH_FILL:   if (walk_done) ph_nxt = PH_COMMIT;
            PH_COMMIT: ph_nxt = PH_SETTLE;
            PH_SETTLE: begin
                if (reload_req)       ph_nxt = PH_FILL;
                else if (settle_done) ph_nxt = PH_LAUNCH;
            end
            PH_LAUNCH: ph_nxt = reload_req ? PH_FILL : PH_RUN;
            PH_RUN:    if (reload_req) ph_nxt = PH_FILL;
            default:   ph_nxt = PH_WAIT;
        endcase
    end

    // Phase-decoded outputs.
    always_comb begin
        walk_start   = (ph != PH_FILL) && (ph_nxt == PH_FILL);
        settle_clear = (ph == PH_COMMIT);
        settle_run   = (ph == PH_SETTLE);
        commit_b     = (ph == PH_COMMIT);
        se_load      = (ph == PH_LAUNCH);
        busy         = (ph == PH_WAIT) || (ph == PH_FILL) || (ph == PH_COMMIT);
    end
endmodule

// File: rtl/cfg_erase_gate.sv
// Erase gate: forwards a page-erase command one cycle later, only when the
// erase-enable bit is set; otherwise the command is dropped.
module cfg_erase_gate #(
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              allow,
    input  logic [PAGE_W-1:0] page_in,
    output logic              fire,
    output logic [PAGE_W-1:0] page
);
    // Register the gated command and its page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire <= 1'b0;
            page <= '0;
        end else begin
            fire <= req && allow;
            if (req && allow) page <= page_in;
        end
    end
endmodule

// File: rtl/cfg_restore_seq.sv
// Top of the configuration restore sequencer. Ties the controller, walker,
// settling timer and erase gate together and answers host requests.
// Assumes the nonvolatile array returns data one cycle after a read.
module cfg_restore_seq
    import cfg_restore_pkg::*;
#(
    parameter int DEPTH     = 48,
    parameter int DATA_W    = 8,
    parameter int PAGE_W    = 4,
    parameter int CLK_HZ    = 200000000,
    parameter int SETTLE_US = 500,
    parameter int ADDR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              reload_req,
    input  logic              host_req,
    output logic              host_ack,
    output logic              host_nack,
    output logic              busy,
    output logic              nv_rd_en,
    output logic [ADDR_W-1:0] nv_rd_addr,
    input  logic [DATA_W-1:0] nv_rd_data,
    output logic              a_wr_en,
    output logic [ADDR_W-1:0] a_wr_addr,
    output logic [DATA_W-1:0] a_wr_data,
    output logic              commit_b,
    output logic              se_load,
    input  logic              erase_req,
    input  logic              erase_allow,
    input  logic [PAGE_W-1:0] erase_page_in,
    output logic              erase_fire,
    output logic [PAGE_W-1:0] erase_page
);
    localparam int SETTLE_CYC = settle_cycles(CLK_HZ, SETTLE_US);

    logic walk_start, walk_done;
    logic settle_clear, settle_run, settle_done;

    cfg_restore_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_ok    (supply_ok),
        .reload_req   (reload_req),
        .walk_done    (walk_done),
        .settle_done  (settle_done),
        .walk_start   (walk_start),
        .settle_clear (settle_clear),
        .settle_run   (settle_run),
        .commit_b     (commit_b),
        .se_load      (se_load),
        .busy         (busy)
    );

    cfg_addr_walker #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (walk_start),
        .rd_en   (nv_rd_en),
        .rd_addr (nv_rd_addr),
        .rd_data (nv_rd_data),
        .wr_en   (a_wr_en),
        .wr_addr (a_wr_addr),
        .wr_data (a_wr_data),
        .done    (walk_done)
    );

    cfg_settle_timer #(
        .CYCLES (SETTLE_CYC)
    ) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (settle_clear),
        .run     (settle_run),
        .expired (settle_done)
    );

    cfg_erase_gate #(
        .PAGE_W (PAGE_W)
    ) u_erase (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (erase_req),
        .allow   (erase_allow),
        .page_in (erase_page_in),
        .fire    (erase_fire),
        .page    (erase_page)
    );

    // Host response: refuse everything while a download runs.
    always_comb begin
        host_nack = host_req && busy;
        host_ack  = host_req && !busy;
    end
endmodule

// File: rtl/cfg_restore_seq_chk.sv
// Property checker for cfg_restore_seq, attached by bind.
module cfg_restore_seq_chk #(
    parameter int DEPTH     = 48,
    parameter int CLK_HZ    = 200000000,
    parameter int SETTLE_US = 500,
    parameter int ADDR_W    = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_req,
    input logic              host_nack,
    input logic              busy,
    input logic              a_wr_en,
    input logic [ADDR_W-1:0] a_wr_addr,
    input logic              commit_b,
    input logic              se_load,
    input logic              erase_req,
    input logic              erase_allow,
    input logic              erase_fire
);
    localparam int SETTLE_CYC = cfg_restore_pkg::settle_cycles(CLK_HZ, SETTLE_US);

    logic        committed;
    logic [31:0] since_commit;

    // Track first commit and cycles elapsed since the latest commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            committed    <= 1'b0;
            since_commit <= '0;
        end else if (commit_b) begin
            committed    <= 1'b1;
            since_commit <= 32'd1;
        end else if (since_commit != '1) begin
            since_commit <= since_commit + 32'd1;
        end
    end

    AST_COMMIT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        commit_b |-> ($past(a_wr_en) && $past(a_wr_addr) == ADDR_W'(DEPTH - 1))); // R3
    AST_COMMIT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_b |-> !a_wr_en); // R3
    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_b |=> !commit_b); // R3
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr_en && a_wr_addr != '0) |-> ($past(a_wr_en) && $past(a_wr_addr) == a_wr_addr - ADDR_W'(1))); // R4
    AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        commit_b |=> !busy); // R5
    AST_EARLY_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!committed && host_req) |-> host_nack); // R6
    AST_LOAD_DISTANCE: assert property (@(posedge clk) disable iff (!rst_n)
        se_load |-> (committed && since_commit == 32'(SETTLE_CYC + 1))); // R7
    AST_ERASE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        erase_fire |-> ($past(erase_req) && $past(erase_allow))); // R10
endmodule

bind cfg_restore_seq cfg_restore_seq_chk #(
    .DEPTH     (DEPTH),
    .CLK_HZ    (CLK_HZ),
    .SETTLE_US (SETTLE_US),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_req    (host_req),
    .host_nack   (host_nack),
    .busy        (busy),
    .a_wr_en     (a_wr_en),
    .a_wr_addr   (a_wr_addr),
    .commit_b    (commit_b),
    .se_load     (se_load),
    .erase_req   (erase_req),
    .erase_allow (erase_allow),
    .erase_fire  (erase_fire)
);

// File: tb/cfg_restore_seq_test.sv
// Directed bench for cfg_restore_seq.
module cfg_restore_seq_test;
    localparam int DEPTH  = 8;
    localparam int DATA_W = 8;
    localparam int PAGE_W = 4;
    localparam int AW     = 3;
    localparam int SETTLE = 2000; // 4 MHz x 500 us

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0, reload_req = 1'b0, host_req = 1'b0;
    logic host_ack, host_nack, busy, nv_rd_en, a_wr_en, commit_b, se_load;
    logic [AW-1:0] nv_rd_addr, a_wr_addr;
    logic [DATA_W-1:0] nv_rd_data = '0, a_wr_data;
    logic erase_req = 1'b0, erase_allow = 1'b0, erase_fire;
    logic [PAGE_W-1:0] erase_page_in = '0, erase_page;

    int total = 0, bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    cfg_restore_seq #(
        .DEPTH(DEPTH), .DATA_W(DATA_W), .PAGE_W(PAGE_W),
        .CLK_HZ(4000000), .SETTLE_US(500)
    ) uut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .reload_req(reload_req),
        .host_req(host_req), .host_ack(host_ack), .host_nack(host_nack), .busy(busy),
        .nv_rd_en(nv_rd_en), .nv_rd_addr(nv_rd_addr), .nv_rd_data(nv_rd_data),
        .a_wr_en(a_wr_en), .a_wr_addr(a_wr_addr), .a_wr_data(a_wr_data),
        .commit_b(commit_b), .se_load(se_load), .erase_req(erase_req),
        .erase_allow(erase_allow), .erase_page_in(erase_page_in),
        .erase_fire(erase_fire), .erase_page(erase_page)
    );

    function automatic logic [DATA_W-1:0] nv_word(input int a);
        return DATA_W'(a * 37 + 5);
    endfunction

    // Nonvolatile array model with one cycle of read latency.
    always @(posedge clk) if (nv_rd_en) nv_rd_data <= nv_word(int'(nv_rd_addr));

    // Monitor sampled on the falling edge.
    int cyc = 0, wr_cnt = 0, commit_cnt = 0, load_cnt = 0;
    int last_wr_cyc = -1, commit_cyc = -1, load_cyc = -1;
    bit order_ok = 1, data_ok = 1, prev_commit = 0, busy_after = 1;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (a_wr_en) begin
                if (int'(a_wr_addr) != wr_cnt) order_ok = 0;
                if (a_wr_data != nv_word(int'(a_wr_addr))) data_ok = 0;
                wr_cnt++;
                last_wr_cyc = cyc;
            end
            if (prev_commit) busy_after = busy;
            prev_commit = commit_b;
            if (commit_b) begin commit_cnt++; commit_cyc = cyc; end
            if (se_load) begin load_cnt++; load_cyc = cyc; end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        wr_cnt = 0; commit_cnt = 0; load_cnt = 0;
        order_ok = 1; data_ok = 1; busy_after = 1;
    endtask

    task automatic wait_load();
        int n = 0;
        while (load_cnt == 0 && n < 5000) begin @(negedge clk); n++; end
    endtask

    task automatic check_download(input string tag);
        check(wr_cnt == DEPTH, tag, wr_cnt, DEPTH);
        check(order_ok && data_ok, "R2", int'(order_ok && data_ok), 1);
        check(commit_cnt == 1, "R3", commit_cnt, 1);
        check(commit_cyc == last_wr_cyc + 1, "R3", commit_cyc - last_wr_cyc, 1);
        check(busy_after == 0, "R5", int'(busy_after), 0);
        check(load_cnt == 1, "R7", load_cnt, 1);
        check(load_cyc - commit_cyc == SETTLE + 1, "R7", load_cyc - commit_cyc, SETTLE + 1);
    endtask

    // R1: reset state, nothing moves while supply_ok is low.
    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b1, "R1", int'(busy), 1);
        check(!nv_rd_en && !a_wr_en && !commit_b && !se_load, "R1",
              int'({nv_rd_en, a_wr_en, commit_b, se_load}), 0);
        repeat (20) @(negedge clk);
        check(wr_cnt == 0 && !nv_rd_en, "R1", wr_cnt, 0);
    endtask

    // R6: refused while busy before the first download.
    task automatic t_host_early();
        host_req = 1'b1;
        @(negedge clk);
        check(host_nack && !host_ack, "R6", int'({host_nack, host_ack}), 2);
        host_req = 1'b0;
    endtask

    // R2 R3 R5 R7: first download after supply clears lockout.
    task automatic t_power_up();
        clear_mon();
        supply_ok = 1'b1;
        wait_load();
        check_download("R2");
        check(wr_cnt == DEPTH, "R4", wr_cnt, DEPTH);
    endtask

    // R6: accepted once idle.
    task automatic t_host_idle();
        host_req = 1'b1;
        @(negedge clk);
        check(host_ack && !host_nack, "R6", int'({host_nack, host_ack}), 1);
        host_req = 1'b0;
        repeat (10) @(negedge clk);
        check(wr_cnt == DEPTH, "R4", wr_cnt, DEPTH);
    endtask

    // R8: command-triggered rerun.
    task automatic t_reload();
        clear_mon();
        reload_req = 1'b1;
        @(negedge clk);
        reload_req = 1'b0;
        check(busy == 1'b1, "R8", int'(busy), 1);
        wait_load();
        check_download("R8");
    endtask

    // R9: second command during a running download is dropped.
    task automatic t_reload_busy();
        clear_mon();
        reload_req = 1'b1;
        @(negedge clk);
        reload_req = 1'b0;
        repeat (3) @(negedge clk);
        reload_req = 1'b1;
        @(negedge clk);
        reload_req = 1'b0;
        wait_load();
        check(wr_cnt == DEPTH, "R9", wr_cnt, DEPTH);
        check(commit_cnt == 1, "R9", commit_cnt, 1);
        repeat (30) @(negedge clk);
        check(wr_cnt == DEPTH && !busy, "R9", wr_cnt, DEPTH);
    endtask

    // R10: erase forwarded only when enabled.
    task automatic t_erase();
        erase_allow = 1'b0; erase_page_in = 4'd9; erase_req = 1'b1;
        @(negedge clk);
        check(erase_fire == 1'b0, "R10", int'(erase_fire), 0);
        erase_req = 1'b0;
        @(negedge clk);
        check(erase_fire == 1'b0, "R10", int'(erase_fire), 0);
        erase_allow = 1'b1; erase_page_in = 4'd6; erase_req = 1'b1;
        @(negedge clk);
        check(erase_fire == 1'b1 && erase_page == 4'd6, "R10", int'(erase_page), 6);
        erase_req = 1'b0;
        @(negedge clk);
        check(erase_fire == 1'b0, "R10", int'(erase_fire), 0);
    endtask

    initial begin
        t_reset();
        t_host_early();
        t_power_up();
        t_host_idle();
        t_reload();
        t_reload_busy();
        t_erase();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule